// File: doc/BRIEF.md
# Serial Montgomery-style modular multiplier

This block multiplies two operands and reduces the product against an odd modulus in the Montgomery domain. With a modulus width of `n` bits, it returns a value congruent to A·B·2^-(n+2) modulo N. It first forms the whole double-width product in one step. It then reduces the lower n+2 product bits at one bit per clock. At the end it adds the upper product bits back in.

The result is kept in the same range as the operands, below 2^(n+1), and may be equal to or above N. No compare against the modulus or final subtraction is needed. Because of this, a result can be fed back as an operand of the next multiplication. Exponentiation loops are the intended user.

The host places the operands and the modulus on the inputs and pulses `start`. The block captures all three in that cycle. It raises `busy` while it works and pulses `done` for one cycle when the result is ready. The result then holds until the next completion.

Top module: `mont_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` and `busy` are 0 and `result` is 0.
- R2: A `start` seen while `busy` is 0 is accepted. `busy` is 1 from the following cycle until the operation completes.
- R3: `done` is 1 for exactly one cycle, MOD_W+3 clock edges after the edge that accepted `start`. In the same edge `busy` returns to 0.
- R4: For odd `modulus` N and operands below 2^(MOD_W+1), `result`·2^(MOD_W+2) ≡ `opa`·`opb` (mod N).
- R5: No final subtraction is applied. Let XM be the product bits above bit MOD_W+1. Then `result` lies between XM and XM+N inclusive, so it is always below 2^(MOD_W+1).
- R6: `opa`, `opb` and `modulus` are captured at the accepting edge. Changing them while `busy` is 1 has no effect on the result.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running operation completes on its original schedule, and no second operation follows.
- R8: `result` changes only at the edge that raises `done`. Between completions it holds, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opa | input | MOD_W+1 | First operand, below 2^(MOD_W+1) |
| opb | input | MOD_W+1 | Second operand, below 2^(MOD_W+1) |
| modulus | input | MOD_W | Odd modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | MOD_W+1 | Montgomery product, held until next completion |

## Verification
If `start` is accepted at rising edge k, `busy` is due after edge k. `done` and the new `result` are due after edge k+MOD_W+3, and `done` falls again after edge k+MOD_W+4. The bench drives inputs and samples outputs on falling edges only. It counts exactly MOD_W+2 falling edges after the first one following the accepting edge, checks that `done` is still low there, and then checks `done` and `result` at the next falling edge. Inputs that are perturbed or restarted mid-run fall inside this same counted window, so the checks still land on the original schedule.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
   typedef enum logic [1:0] {
      MM_IDLE  = 2'd0,
      MM_RUN   = 2'd1,
      MM_FINAL = 2'd2
   } mm_state_e;
endpackage

// File: rtl/mmul_product.sv
module mmul_product #(
   parameter int OPW        = 33,
   parameter int MULT_STYLE = 0,
   localparam int PW        = 2 * OPW
) (
   input  logic [OPW-1:0] a,
   input  logic [OPW-1:0] b,
   output logic [PW-1:0]  p
);
   generate
      if (MULT_STYLE == 0) begin : g_direct
         assign p = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
      end else begin : g_shift_add
         logic [PW-1:0] acc [0:OPW];
         assign acc[0] = '0;
         for (genvar i = 0; i < OPW; i++) begin : g_row
            assign acc[i+1] = acc[i] + (a[i] ? ({{OPW{1'b0}}, b} << i) : '0);
         end
         assign p = acc[OPW];
      end
   endgenerate
endmodule

// File: rtl/mmul_reduce.sv
module mmul_reduce #(
   parameter int MOD_W = 32,
   localparam int OPW  = MOD_W + 1,
   localparam int LW   = MOD_W + 2,
   localparam int PW   = 2 * OPW,
   localparam int SUMW = MOD_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [PW-1:0]    prod,
   input  logic [MOD_W-1:0] modulus,
   output logic [OPW-1:0]   final_sum
);
   logic [LW-1:0]    low_q;
   logic [MOD_W-1:0] high_q;
   logic [MOD_W-1:0] mod_q;
   logic [OPW-1:0]   s_q;
   logic             qbit;
   logic [SUMW-1:0]  add_s, add_x, add_n;
   logic [OPW-1:0]   s_nxt;

   assign qbit  = s_q[0] ^ low_q[0];
   assign add_s = {1'b0, s_q};
   assign add_x = {{(SUMW-1){1'b0}}, low_q[0]};
   assign add_n = qbit ? {2'b00, mod_q} : '0;
   assign s_nxt = OPW'((add_s + add_x + add_n) >> 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_q  <= '0;
         high_q <= '0;
         mod_q  <= '0;
         s_q    <= '0;
      end else if (load) begin
         low_q  <= prod[LW-1:0];
         high_q <= prod[PW-1:LW];
         mod_q  <= modulus;
         s_q    <= '0;
      end else if (step) begin
         low_q  <= low_q >> 1;
         s_q    <= s_nxt;
      end
   end

   assign final_sum = s_q + {1'b0, high_q};
endmodule

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
   import mmul_pkg::*;
#(
   parameter int MOD_W = 32,
   localparam int STEPS = MOD_W + 2,
   localparam int CW    = $clog2(STEPS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic finish,
   output logic busy
);
   mm_state_e state_q;
   logic [CW-1:0] cnt_q;

   assign load   = start && (state_q == MM_IDLE);
   assign step   = (state_q == MM_RUN);
   assign finish = (state_q == MM_FINAL);
   assign busy   = (state_q != MM_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MM_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            MM_IDLE: if (start) begin
               state_q <= MM_RUN;
               cnt_q   <= '0;
            end
            MM_RUN: begin
               if (cnt_q == CW'(STEPS - 1)) state_q <= MM_FINAL;
               else cnt_q <= cnt_q + 1'b1;
            end
            MM_FINAL: state_q <= MM_IDLE;
            default:  state_q <= MM_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
   parameter int MOD_W      = 32,
   parameter int MULT_STYLE = 1,
   localparam int OPW       = MOD_W + 1,
   localparam int PW        = 2 * OPW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPW-1:0]   opa,
   input  logic [OPW-1:0]   opb,
   input  logic [MOD_W-1:0] modulus,
   output logic             busy,
   output logic             done,
   output logic [OPW-1:0]   result
);
   generate
      if (MOD_W < 2) begin : g_bad_width
         $error("mont_mul: MOD_W must be at least 2");
      end
      if (MULT_STYLE != 0 && MULT_STYLE != 1) begin : g_bad_style
         $error("mont_mul: MULT_STYLE must be 0 or 1");
      end
   endgenerate

   logic          load, step, finish;
   logic [PW-1:0] prod;
   logic [OPW-1:0] fsum;
   logic          done_q;
   logic [OPW-1:0] result_q;

   mmul_ctrl #(.MOD_W(MOD_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .finish(finish), .busy(busy)
   );

   mmul_product #(.OPW(OPW), .MULT_STYLE(MULT_STYLE)) u_prod (
      .a(opa), .b(opb), .p(prod)
   );

   mmul_reduce #(.MOD_W(MOD_W)) u_red (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .prod(prod), .modulus(modulus), .final_sum(fsum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= finish;
         if (finish) result_q <= fsum;
      end
   end

   assign done   = done_q;
   assign result = result_q;
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
   parameter int MOD_W = 32,
   localparam int OPW  = MOD_W + 1,
   localparam int LATW = $clog2(MOD_W + 4) + 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic [OPW-1:0] result
);
   logic [LATW-1:0] lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              lat_q <= '0;
      else if (start && !busy) lat_q <= '0;
      else if (busy)           lat_q <= lat_q + 1'b1;
   end

   assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LATW'(MOD_W + 3)));

   assert_busy_ends_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
endmodule

bind mont_mul mont_mul_chk #(.MOD_W(MOD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .busy(busy), .done(done), .result(result)
);

// File: tb/mont_mul_test.sv
`timescale 1ns/1ps
module mont_mul_test;
   localparam int NW  = 5;
   localparam int OPW = NW + 1;
   localparam int OPMAX = 1 << OPW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [OPW-1:0] opa = '0;
   logic [OPW-1:0] opb = '0;
   logic [NW-1:0]  modulus = '0;
   logic           busy, done;
   logic [OPW-1:0] result;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mont_mul #(.MOD_W(NW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .opa(opa), .opb(opb), .modulus(modulus),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R4 congruence and R5 range of the returned value
   task automatic verify(input longint a, input longint b, input longint m, input longint res);
      longint xm, lhs, rhs;
      xm  = (a * b) >> (NW + 2);
      lhs = (res << (NW + 2)) % m;
      rhs = (a * b) % m;
      chk(lhs == rhs, "R4 congruence", lhs, rhs);
      chk(res >= xm && res - xm <= m && res < OPMAX, "R5 range", res, xm);
   endtask

   // called on a falling edge; returns on the falling edge after done rises
   task automatic run_op(input int a, input int b, input int m,
                         input bit perturb, input bit restart, output int res);
      opa = OPW'(a); opb = OPW'(b); modulus = NW'(m);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after accept", busy, 1);
      chk(done == 1'b0, "R3 done single cycle", done, 0);
      if (perturb) begin
         opa = ~OPW'(a); opb = OPW'(b + 7); modulus = NW'(m ^ 6);
      end
      for (int i = 0; i < NW + 2; i++) begin
         if (restart && i == 2) start = 1'b1;
         if (restart && i == 3) start = 1'b0;
         @(negedge clk);
      end
      chk(done == 1'b0, "R3 done not early", done, 0);
      @(negedge clk);
      chk(done == 1'b1, "R3 done on time", done, 1);
      chk(busy == 1'b0, "R3 busy drops with done", busy, 0);
      res = int'(result);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int res, held;
      int mods [4] = '{17, 31, 21, 19};
      int edge_ops [6];
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0 && busy == 1'b0, "R1 reset flags", {done, busy}, 0);
      chk(result == '0, "R1 reset result", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0 && result == '0, "R1 after reset", result, 0);

      // R4/R5 exhaustive sweep for one modulus
      for (int a = 0; a < OPMAX; a++)
         for (int b = 0; b < OPMAX; b++) begin
            run_op(a, b, 29, 1'b0, 1'b0, res);
            verify(a, b, 29, res);
         end

      // R4/R5 boundary operands for other odd moduli
      foreach (mods[k]) begin
         edge_ops = '{0, 1, mods[k] - 1, mods[k], OPMAX - 2, OPMAX - 1};
         foreach (edge_ops[j])
            for (int b = 0; b < OPMAX; b++) begin
               run_op(edge_ops[j], b, mods[k], 1'b0, 1'b0, res);
               verify(edge_ops[j], b, mods[k], res);
            end
      end

      // R6 inputs changed during the run are ignored
      run_op(45, 58, 27, 1'b1, 1'b0, res);
      verify(45, 58, 27, res);
      run_op(63, 63, 31, 1'b1, 1'b0, res);
      verify(63, 63, 31, res);

      // R7 start while busy: original schedule, no second run
      run_op(33, 50, 23, 1'b0, 1'b1, res);
      verify(33, 50, 23, res);
      @(negedge clk);
      chk(busy == 1'b0, "R7 no restart", busy, 0);
      chk(done == 1'b0, "R7 no second done", done, 0);

      // R8 result holds without a new start
      held = res;
      opa = 6'd12; opb = 6'd40; modulus = 5'd9;
      repeat (6) @(negedge clk);
      chk(int'(result) == held, "R8 result held", result, held);
      chk(done == 1'b0 && busy == 1'b0, "R8 stays idle", {done, busy}, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule